// File: doc/BRIEF.md
# Multi-Layout 2B+D Serial Frame Port

This block connects the parallel channel registers of an ISDN basic access path to a five-wire serial bus. The two 64 kbit/s B channels and the 16 kbit/s D channel of one 8 kHz frame move over that bus. The bus carries a bit clock, a serial data input (`tx_ser_i`), a serial data output (`rx_ser_o`) and a separate frame sync for each direction. The bit clock and the syncs are sampled in the system clock domain. The system clock must run several times faster than the bit clock.

Three fixed layouts place B1, B2 and D at the start of the frame:
- A compact 18-bit layout.
- A split-D layout of 19 bits, which puts one D bit after each B byte.
- A half-rate layout of 26 bits, which holds each bit for two bit clocks.

The sync can mark the first bit directly (non-delayed) or one bit ahead of it (delayed). In slave mode the syncs are inputs. In master mode the block generates both syncs from its own frame counter. At the last assigned bit of a frame, the channel bits taken from the serial input are presented as parallel bytes together with a one-cycle strobe. The bytes waiting on the parallel inputs are shifted out during the assigned bits of the next frame.

Top module: `isdn_frame_port`

## Requirements
- R1: With `cfg_layout_i`=0, frame bit positions 0-7 carry B1, 8-15 carry B2 and 16-17 carry D. Each field is sent MSB first, and positions 18 and later are unassigned.
- R2: With `cfg_layout_i`=1, position 8 carries D bit 1 and position 9 is unassigned. B2 takes positions 10-17 and position 18 carries D bit 0. B1 takes positions 0-7.
- R3: With `cfg_layout_i`=2, each frame bit lasts two bit clock periods. B1 takes positions 0-7, B2 takes 8-15, positions 16-23 are unassigned and D takes 24-25. The input is sampled on the second falling edge of each bit, which is 1.5 periods after the rising edge that started it.
- R4: With `cfg_delayed_i`=0 in slave mode, a frame begins at the rising bit clock edge where the sync is first seen high.
- R5: With `cfg_delayed_i`=1 in slave mode, a sync seen newly high at a falling bit clock edge makes the next rising edge the start of a frame.
- R6: The serial output is driven only during assigned bits and changes right after rising bit clock edges. At all other times `rx_en_o` is 0 and `rx_ser_o` is high impedance.
- R7: `cfg_err_o` is 1 for layout 3, for layout 1 without delayed timing, and for layout 2 with delayed timing. While it is 1 the output stays undriven, no capture strobe occurs and the master syncs stay low.
- R8: In master mode with non-delayed timing, `fsx_o` is high during frame bits 0-7 and `fsr_o` is high during bits 8-15. The frame is `FRAME_BCLK` bit clocks long.
- R9: In master mode with delayed timing, `fsx_o` is high for the single bit clock period before bit 0, and `fsr_o` is high for the period before bit 8.
- R10: At the last assigned bit, `cap_b1_o`, `cap_b2_o` and `cap_d_o` update and `cap_valid_o` pulses for exactly one clock. The captured outputs never change at any other time.
- R11: After reset all outputs are 0 and the serial output is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_layout_i | input | 2 | Frame layout: 0 compact, 1 split-D, 2 half-rate, 3 illegal |
| cfg_delayed_i | input | 1 | 1 selects delayed sync timing |
| cfg_master_i | input | 1 | 1 generates syncs, 0 takes them from the bus |
| bclk_i | input | 1 | Serial bit clock |
| fsx_i | input | 1 | Input-side frame sync (slave mode) |
| fsr_i | input | 1 | Output-side frame sync (slave mode) |
| tx_ser_i | input | 1 | Serial data into the block |
| rx_ser_o | output | 1 | Serial data out of the block, tri-stated when idle |
| rx_en_o | output | 1 | High while `rx_ser_o` is driven |
| fsx_o | output | 1 | Generated first-slot sync (master mode) |
| fsr_o | output | 1 | Generated second-slot sync (master mode) |
| drv_b1_i | input | 8 | B1 byte to shift out |
| drv_b2_i | input | 8 | B2 byte to shift out |
| drv_d_i | input | 2 | D bits to shift out |
| cap_b1_o | output | 8 | Captured B1 byte |
| cap_b2_o | output | 8 | Captured B2 byte |
| cap_d_o | output | 2 | Captured D bits |
| cap_valid_o | output | 1 | One-clock strobe when a frame's capture completes |
| cfg_err_o | output | 1 | Illegal layout/timing combination |

## Verification
The checker watches four properties on every cycle:
- The capture strobe lasts a single clock.
- The captured bytes change only together with that strobe.
- No strobe follows a cycle in which the configuration was illegal.
- The output enable changes only while the bit clock is high, and the two generated syncs are never high together.

The bench scenarios cover what these properties cannot show. They check that every bit lands in its layout position in the correct order, that frame alignment is correct under both sync phases, that half-rate sampling uses the right edge, and that the master sync waveforms are correct.

// File: rtl/isdn_fp_pkg.sv
`timescale 1ns/1ps
package isdn_fp_pkg;

   localparam logic [1:0] LAY_COMPACT = 2'd0;
   localparam logic [1:0] LAY_SPLIT_D = 2'd1;
   localparam logic [1:0] LAY_HALF    = 2'd2;

   typedef enum logic [1:0] {CH_NONE, CH_B1, CH_B2, CH_D} chan_e;

   typedef struct packed {
      chan_e      ch;
      logic [2:0] idx;   // 0 = most significant bit of the field
   } slot_t;

   function automatic slot_t map_slot(input logic [1:0] lay, input int unsigned p);
      slot_t s;
      s = '{ch: CH_NONE, idx: 3'd0};
      if (p < 8) begin
         if (lay != 2'd3) s = '{ch: CH_B1, idx: 3'(p)};
      end else begin
         case (lay)
            LAY_COMPACT: begin
               if (p < 16)      s = '{ch: CH_B2, idx: 3'(p - 8)};
               else if (p < 18) s = '{ch: CH_D,  idx: 3'(p - 16)};
            end
            LAY_SPLIT_D: begin
               if (p == 8)                s = '{ch: CH_D,  idx: 3'd0};
               else if (p >= 10 && p < 18) s = '{ch: CH_B2, idx: 3'(p - 10)};
               else if (p == 18)          s = '{ch: CH_D,  idx: 3'd1};
            end
            LAY_HALF: begin
               if (p < 16)                 s = '{ch: CH_B2, idx: 3'(p - 8)};
               else if (p == 24 || p == 25) s = '{ch: CH_D,  idx: 3'(p - 24)};
            end
            default: s = '{ch: CH_NONE, idx: 3'd0};
         endcase
      end
      return s;
   endfunction

   function automatic int unsigned last_pos(input logic [1:0] lay);
      case (lay)
         LAY_COMPACT: return 17;
         LAY_SPLIT_D: return 18;
         LAY_HALF:    return 25;
         default:     return 0;
      endcase
   endfunction

   function automatic logic cfg_bad(input logic [1:0] lay, input logic dly);
      return (lay == 2'd3) || (lay == LAY_SPLIT_D && !dly) || (lay == LAY_HALF && dly);
   endfunction

endpackage

// File: rtl/isdn_fp_timer.sv
`timescale 1ns/1ps
module isdn_fp_timer #(
   parameter int unsigned FRAME_BCLK = 64,
   localparam int unsigned CW = $clog2(FRAME_BCLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          fall,
   input  logic          master,
   input  logic          delayed,
   input  logic          fs_i,
   output logic [CW-1:0] cnt,
   output logic          act,
   output logic          start
);
   localparam logic [CW-1:0] LAST = CW'(FRAME_BCLK - 1);

   logic fs_at_rise_q, fs_at_fall_q, pend_q;

   always_comb begin
      if (master)       start = rise && (!act || cnt == LAST);
      else if (delayed) start = rise && pend_q;
      else              start = rise && fs_i && !fs_at_rise_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_at_rise_q <= 1'b0;
         fs_at_fall_q <= 1'b0;
         pend_q       <= 1'b0;
         cnt          <= '0;
         act          <= 1'b0;
      end else begin
         if (rise) fs_at_rise_q <= fs_i;
         if (fall) fs_at_fall_q <= fs_i;
         if (!delayed || master || start)      pend_q <= 1'b0;
         else if (fall && fs_i && !fs_at_fall_q) pend_q <= 1'b1;
         if (start) begin
            cnt <= '0;
            act <= 1'b1;
         end else if (rise && act) begin
            if (cnt == LAST) act <= 1'b0;
            else             cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/isdn_fp_capture.sv
`timescale 1ns/1ps
module isdn_fp_capture
   import isdn_fp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev,
   input  logic        last,
   input  slot_t       slot,
   input  logic        bit_i,
   output logic [7:0]  b1_o,
   output logic [7:0]  b2_o,
   output logic [1:0]  d_o,
   output logic        valid_o
);
   logic [7:0] b1_s, b2_s, b1_n, b2_n;
   logic [1:0] d_s, d_n;

   always_comb begin
      b1_n = b1_s;
      b2_n = b2_s;
      d_n  = d_s;
      case (slot.ch)
         CH_B1:   b1_n[3'd7 - slot.idx] = bit_i;
         CH_B2:   b2_n[3'd7 - slot.idx] = bit_i;
         CH_D:    d_n[~slot.idx[0]]     = bit_i;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b1_s <= '0; b2_s <= '0; d_s <= '0;
         b1_o <= '0; b2_o <= '0; d_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= ev && last;
         if (ev) begin
            b1_s <= b1_n; b2_s <= b2_n; d_s <= d_n;
         end
         if (ev && last) begin
            b1_o <= b1_n; b2_o <= b2_n; d_o <= d_n;
         end
      end
   end
endmodule

// File: rtl/isdn_fp_drive.sv
`timescale 1ns/1ps
module isdn_fp_drive
   import isdn_fp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic       load,
   input  logic       act,
   input  logic       err,
   input  slot_t      slot,
   input  logic [7:0] b1_i,
   input  logic [7:0] b2_i,
   input  logic [1:0] d_i,
   output logic       ser_o,
   output logic       en_o
);
   logic [7:0] b1_q, b2_q, b1_src, b2_src;
   logic [1:0] d_q, d_src;
   logic       sel_bit;

   assign b1_src = load ? b1_i : b1_q;
   assign b2_src = load ? b2_i : b2_q;
   assign d_src  = load ? d_i  : d_q;

   always_comb begin
      case (slot.ch)
         CH_B1:   sel_bit = b1_src[3'd7 - slot.idx];
         CH_B2:   sel_bit = b2_src[3'd7 - slot.idx];
         CH_D:    sel_bit = d_src[~slot.idx[0]];
         default: sel_bit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b1_q <= '0; b2_q <= '0; d_q <= '0;
         ser_o <= 1'b0;
         en_o  <= 1'b0;
      end else begin
         if (load) begin
            b1_q <= b1_i; b2_q <= b2_i; d_q <= d_i;
         end
         if (upd) begin
            en_o  <= act && !err && (slot.ch != CH_NONE);
            ser_o <= sel_bit;
         end
      end
   end
endmodule

// File: rtl/isdn_frame_port.sv
`timescale 1ns/1ps
module isdn_frame_port
   import isdn_fp_pkg::*;
#(
   parameter int unsigned FRAME_BCLK = 64,
   parameter bit          TRI_STATE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_layout_i,
   input  logic       cfg_delayed_i,
   input  logic       cfg_master_i,
   input  logic       bclk_i,
   input  logic       fsx_i,
   input  logic       fsr_i,
   input  logic       tx_ser_i,
   output logic       rx_ser_o,
   output logic       rx_en_o,
   output logic       fsx_o,
   output logic       fsr_o,
   input  logic [7:0] drv_b1_i,
   input  logic [7:0] drv_b2_i,
   input  logic [1:0] drv_d_i,
   output logic [7:0] cap_b1_o,
   output logic [7:0] cap_b2_o,
   output logic [1:0] cap_d_o,
   output logic       cap_valid_o,
   output logic       cfg_err_o
);
   localparam int unsigned CW       = $clog2(FRAME_BCLK);
   localparam int unsigned MIN_BCLK = 2 * 26;

   if (FRAME_BCLK < MIN_BCLK) begin : g_len_chk
      $error("FRAME_BCLK must cover the half-rate layout");
   end

   logic          bclk_q, rise, fall, rise_d, rx_start_d;
   logic          half, err;
   logic [CW-1:0] tx_cnt, rx_cnt, tx_pos, rx_pos;
   logic          tx_act, rx_act, tx_start, rx_start;
   slot_t         tx_slot, rx_slot;
   logic          tx_ev, tx_last, ser_d;

   assign rise = bclk_i & ~bclk_q;
   assign fall = ~bclk_i & bclk_q;
   assign err  = cfg_bad(cfg_layout_i, cfg_delayed_i);
   assign half = (cfg_layout_i == LAY_HALF);
   assign cfg_err_o = err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q     <= 1'b0;
         rise_d     <= 1'b0;
         rx_start_d <= 1'b0;
      end else begin
         bclk_q     <= bclk_i;
         rise_d     <= rise;
         rx_start_d <= rx_start;
      end
   end

   isdn_fp_timer #(.FRAME_BCLK(FRAME_BCLK)) u_tx_tmr (
      .clk, .rst_n, .rise, .fall, .master(cfg_master_i), .delayed(cfg_delayed_i),
      .fs_i(fsx_i), .cnt(tx_cnt), .act(tx_act), .start(tx_start));

   isdn_fp_timer #(.FRAME_BCLK(FRAME_BCLK)) u_rx_tmr (
      .clk, .rst_n, .rise, .fall, .master(cfg_master_i), .delayed(cfg_delayed_i),
      .fs_i(fsr_i), .cnt(rx_cnt), .act(rx_act), .start(rx_start));

   assign tx_pos  = half ? (tx_cnt >> 1) : tx_cnt;
   assign rx_pos  = half ? (rx_cnt >> 1) : rx_cnt;
   assign tx_slot = map_slot(cfg_layout_i, int'(tx_pos));
   assign rx_slot = map_slot(cfg_layout_i, int'(rx_pos));
   assign tx_last = (int'(tx_pos) == last_pos(cfg_layout_i));
   assign tx_ev   = fall && tx_act && !err && (tx_slot.ch != CH_NONE) && (!half || tx_cnt[0]);

   isdn_fp_capture u_cap (
      .clk, .rst_n, .ev(tx_ev), .last(tx_last), .slot(tx_slot), .bit_i(tx_ser_i),
      .b1_o(cap_b1_o), .b2_o(cap_b2_o), .d_o(cap_d_o), .valid_o(cap_valid_o));

   isdn_fp_drive u_drv (
      .clk, .rst_n, .upd(rise_d), .load(rx_start_d), .act(rx_act), .err, .slot(rx_slot),
      .b1_i(drv_b1_i), .b2_i(drv_b2_i), .d_i(drv_d_i), .ser_o(ser_d), .en_o(rx_en_o));

   if (TRI_STATE) begin : g_tri
      assign rx_ser_o = rx_en_o ? ser_d : 1'bz;
   end else begin : g_gated
      assign rx_ser_o = rx_en_o & ser_d;
   end

   always_comb begin
      fsx_o = 1'b0;
      fsr_o = 1'b0;
      if (cfg_master_i && !err && tx_act) begin
         if (cfg_delayed_i) begin
            fsx_o = (tx_cnt == CW'(FRAME_BCLK - 1));
            fsr_o = (tx_cnt == CW'(7));
         end else begin
            fsx_o = (tx_pos < CW'(8));
            fsr_o = (tx_pos >= CW'(8)) && (tx_pos < CW'(16));
         end
      end
   end
endmodule

module isdn_frame_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bclk_i,
   input logic       cfg_err_o,
   input logic       rx_en_o,
   input logic       cap_valid_o,
   input logic [7:0] cap_b1_o,
   input logic       fsx_o,
   input logic       fsr_o
);
   AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_o |=> !cap_valid_o); // R10
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(cap_b1_o) |-> cap_valid_o); // R10
   AST_NO_CAP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_err_o) |-> !cap_valid_o); // R7
   AST_EN_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(rx_en_o) && $stable(cfg_err_o)) |-> bclk_i); // R6
   AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fsx_o && fsr_o)); // R8
endmodule

bind isdn_frame_port isdn_frame_port_chk chk_i (.*);

// File: tb/isdn_frame_port_tb.sv
`timescale 1ns/1ps
module isdn_frame_port_tb_top;
   localparam int FRAME = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_layout_i = 2'd0;
   logic       cfg_delayed_i = 1'b0, cfg_master_i = 1'b0;
   logic       bclk_i = 1'b0, fsx_i = 1'b0, fsr_i = 1'b0, tx_ser_i = 1'b0;
   logic       rx_ser_o, rx_en_o, fsx_o, fsr_o, cap_valid_o, cfg_err_o;
   logic [7:0] drv_b1_i = '0, drv_b2_i = '0, cap_b1_o, cap_b2_o;
   logic [1:0] drv_d_i = '0, cap_d_o;

   int n_chk = 0, n_fail = 0, v_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   isdn_frame_port #(.FRAME_BCLK(FRAME)) dut_i (.*);

   always @(posedge clk) if (cap_valid_o) v_cnt++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // kind: 0 none, 1 B1, 2 B2, 3 D; idx counts from the field's MSB
   function automatic void bmap(input int lay, input int p, output int kind, output int idx);
      kind = 0; idx = 0;
      if (lay == 3 || p < 0) return;
      if (p < 8) begin kind = 1; idx = p; return; end
      if (lay == 1) begin
         if (p == 8)       begin kind = 3; idx = 0; end
         else if (p == 18) begin kind = 3; idx = 1; end
         else if (p >= 10 && p <= 17) begin kind = 2; idx = p - 10; end
      end else begin
         if (p < 16) begin kind = 2; idx = p - 8; end
         else if (lay == 0 && p < 18) begin kind = 3; idx = p - 16; end
         else if (lay == 2 && (p == 24 || p == 25)) begin kind = 3; idx = p - 24; end
      end
   endfunction

   function automatic logic pick(input int kind, input int idx,
                                 input logic [7:0] a, input logic [7:0] b, input logic [1:0] d);
      case (kind)
         1: return a[7 - idx];
         2: return b[7 - idx];
         3: return d[1 - idx];
         default: return 1'b1;
      endcase
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; bclk_i = 1'b0; fsx_i = 1'b0; fsr_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_slave(input int lay, input bit dly, input int pi);
      logic [7:0] b1, b2, r1, r2;
      logic [1:0] d, rd;
      bit bad, half;
      int v0;
      string ltag;
      b1 = 8'(8'h5A ^ (pi * 37 + lay * 11));
      b2 = 8'(8'hC3 + pi * 29);
      d  = 2'(pi + lay);
      r1 = 8'(8'h81 ^ (pi * 53));
      r2 = 8'(8'h3C + pi * 71 + lay);
      rd = 2'(3 - pi);
      bad  = (lay == 3) || (lay == 1 && !dly) || (lay == 2 && dly);
      half = (lay == 2);
      ltag = (lay == 0) ? "R1" : (lay == 1) ? "R2" : "R3";
      cfg_master_i = 1'b0; cfg_layout_i = 2'(lay); cfg_delayed_i = dly;
      drv_b1_i = r1; drv_b2_i = r2; drv_d_i = rd;
      @(negedge clk);
      chk(cfg_err_o == bad, "R7 cfg_err", int'(cfg_err_o), int'(bad));
      v0 = v_cnt;
      for (int k = -1; k < FRAME; k++) begin
         int p, kind, idx;
         bit fs, exp_en;
         p = (k < 0) ? -1 : (half ? k / 2 : k);
         bmap(lay, p, kind, idx);
         fs = dly ? (k == -1) : (k >= 0 && k < 8);
         fsx_i = fs; fsr_i = fs;
         tx_ser_i = pick(kind, idx, b1, b2, d);
         bclk_i = 1'b1;
         repeat (3) @(negedge clk);
         exp_en = !bad && kind != 0;
         chk(rx_en_o == exp_en, bad ? "R7 enable" : (exp_en ? ltag : "R6"), int'(rx_en_o), int'(exp_en));
         if (exp_en) begin
            logic eb;
            eb = pick(kind, idx, r1, r2, rd);
            chk(rx_ser_o == eb, ltag, int'(rx_ser_o), int'(eb));
         end
         @(negedge clk); bclk_i = 1'b0;
         repeat (4) @(negedge clk);
      end
      fsx_i = 1'b0; fsr_i = 1'b0;
      chk((v_cnt - v0) == (bad ? 0 : 1), bad ? "R7 strobe" : "R10 strobe", v_cnt - v0, bad ? 0 : 1);
      if (!bad) begin
         chk(cap_b1_o == b1, dly ? "R5 b1" : "R4 b1", int'(cap_b1_o), int'(b1));
         chk(cap_b2_o == b2, ltag, int'(cap_b2_o), int'(b2));
         chk(cap_d_o == d, ltag, int'(cap_d_o), int'(d));
      end
   endtask

   task automatic run_master(input int lay, input bit dly);
      cfg_master_i = 1'b1; cfg_layout_i = 2'(lay); cfg_delayed_i = dly;
      do_reset();
      for (int k = 0; k < 2 * FRAME; k++) begin
         int m, p;
         bit ex, er;
         m = k % FRAME;
         p = (lay == 2) ? m / 2 : m;
         ex = dly ? (m == FRAME - 1) : (p < 8);
         er = dly ? (m == 7) : (p >= 8 && p < 16);
         bclk_i = 1'b1;
         repeat (3) @(negedge clk);
         chk(fsx_o == ex, dly ? "R9 fsx" : "R8 fsx", int'(fsx_o), int'(ex));
         chk(fsr_o == er, dly ? "R9 fsr" : "R8 fsr", int'(fsr_o), int'(er));
         @(negedge clk); bclk_i = 1'b0;
         repeat (4) @(negedge clk);
      end
      cfg_master_i = 1'b0;
   endtask

   initial begin
      do_reset();
      chk(rx_en_o == 1'b0, "R11 enable", int'(rx_en_o), 0);
      chk(cap_valid_o == 1'b0, "R11 strobe", int'(cap_valid_o), 0);
      chk(cap_b1_o == 8'd0 && cap_b2_o == 8'd0 && cap_d_o == 2'd0, "R11 capture", int'(cap_b1_o), 0);
      chk(fsx_o == 1'b0 && fsr_o == 1'b0, "R11 syncs", int'(fsx_o), 0);
      for (int lay = 0; lay < 4; lay++)
         for (int dl = 0; dl < 2; dl++)
            for (int pi = 0; pi < 3; pi++)
               run_slave(lay, dl[0], pi);
      run_master(0, 1'b0);
      run_master(2, 1'b0);
      run_master(0, 1'b1);
      run_master(1, 1'b1);
      cfg_layout_i = 2'd1; cfg_delayed_i = 1'b0; cfg_master_i = 1'b1;
      do_reset();
      repeat (2) begin
         bclk_i = 1'b1; repeat (3) @(negedge clk);
         chk(fsx_o == 1'b0 && fsr_o == 1'b0, "R7 master syncs", int'(fsx_o | fsr_o), 0);
         @(negedge clk); bclk_i = 1'b0; repeat (4) @(negedge clk);
      end
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule